// File: doc/BRIEF.md
# Three-wire serial EEPROM device engine

This block is the device side of a three-wire serial EEPROM that stores 16-bit words. A host drives chip select, a serial clock and a serial data input. The block answers on a serial data output with a separate output enable, which stands in for a tri-state pin. The block decodes each instruction from the bit stream and serves it from a small internal word array. It handles reads that run on through the array, writes guarded by a write-enable latch, and a self-timed programming period whose progress the host can poll on the data output.

Chip select, serial clock and data input are brought into the system clock domain through two-stage synchronizers, and a serial clock rising edge is detected there. Everything else runs on the system clock. The host's serial clock must therefore be several system clocks per half period. Parameters set the address width, the word width, the programming time in system clock cycles, and which event starts programming: the chip select falling after the last data bit, or the edge that captures that bit.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is high and no instruction is in progress, 0 bits on the data input are skipped. The first 1 is taken as the start bit, so leading "1", "01" and "001" all begin an instruction.
- R2: The start bit is followed by a 2-bit opcode, then ADDR_W address bits, most significant bit first. Opcode 10 is a read and 01 is a write. For opcode 00, the top two address bits select the command: 11 sets the write-enable latch, 00 clears it, and 01 (fill-all) and 10 are ignored. Opcode 11 is ignored.
- R3: Reset clears the write-enable latch. While the latch is clear, a write changes no word and starts no programming period. The latch stays set until a clear command arrives.
- R4: On a read, the serial clock rising edge that captures the last address bit makes the output drive a single 0. The next 16 rising edges present the addressed word, most significant bit first. A read works whatever the latch state.
- R5: If clocking continues after a read word, the next word follows with no extra 0 bit. The address increments by one and wraps from 2^ADDR_W-1 to 0.
- R6: A write carries 16 data bits, most significant first, after the address. With the default setting, programming begins when chip select falls after the 16th data bit. If chip select falls before the 16th data bit, nothing is written.
- R7: Programming lasts PROG_CYCLES system clocks, and the word is stored at its end. From the start of programming, whenever chip select is high, the output is enabled and shows 0 while busy and 1 once ready. This status stays on until the next start bit is taken.
- R8: While chip select is low, the output enable is low, and a low chip select abandons any instruction in progress.
- R9: While programming is in progress, start bits are not taken. A whole instruction sent during that time has no effect, and the status keeps showing.
- R10: After reset the output enable is low and every word of the array reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, asynchronous to clk |
| sk | input | 1 | Serial clock from the host, asynchronous to clk |
| di | input | 1 | Serial data input, sampled on serial clock rising edges |
| do_o | output | 1 | Serial data output value |
| do_oe | output | 1 | Output enable for do_o; low means high impedance |

## Verification
A bit counter that is off by one shows up as a read word shifted by one position or a missing leading 0, within the first word. A wrong address increment shows up at the word boundary of a continued read. A latch or busy flag in the wrong state shows as a word that changes when it should not, or as a status bit at the wrong level. The status bit can be seen a few system clocks after chip select rises. A changed word is visible on the next read.

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int PROG_CYCLES = 400,
  parameter bit PROG_ON_CS_FALL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXB  = (WORD_W > ADDR_W) ? WORD_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXB) + 1;
  localparam int PT_W  = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_RD, S_WR, S_SKIP} st_t;

  logic [2:0] cs_p, sk_p;
  logic [1:0] di_p;
  st_t state;
  logic [CNT_W-1:0] cnt;
  logic [1:0] op;
  logic [ADDR_W-1:0] addr, wr_addr;
  logic [WORD_W-1:0] rsh, dsh, wr_word;
  logic [WORD_W-1:0] mem [DEPTH];
  logic wen, busy, status, rd_drive, do_q, wr_pend;
  logic [PT_W-1:0] ptimer;

  wire cs_q    = cs_p[1];
  wire cs_fall = cs_p[2] & ~cs_p[1];
  wire sk_rise = sk_p[1] & ~sk_p[2];
  wire bit_in  = di_p[1];
  wire tick    = cs_q & sk_rise;
  wire start_ok  = tick & (state == S_IDLE) & bit_in & ~busy;
  wire last_data = tick & (state == S_WR) & (cnt == CNT_W'(WORD_W - 1));
  wire launch    = PROG_ON_CS_FALL ? (cs_fall & wr_pend) : (last_data & wen);
  wire commit    = busy & (ptimer == '0);
  wire [ADDR_W-1:0] a_next = {addr[ADDR_W-2:0], bit_in};

  assign do_o  = status ? ~busy : do_q;
  assign do_oe = cs_q & (status | rd_drive);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0;
      sk_p <= '0;
      di_p <= '0;
    end else begin
      cs_p <= {cs_p[1:0], cs};
      sk_p <= {sk_p[1:0], sk};
      di_p <= {di_p[0], di};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      status <= 1'b0;
      ptimer <= '0;
    end else begin
      if (start_ok) status <= 1'b0;
      if (launch) begin
        busy   <= 1'b1;
        status <= 1'b1;
        ptimer <= PT_W'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (ptimer == '0) busy <= 1'b0;
        else ptimer <= ptimer - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[wr_addr] <= wr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      op       <= '0;
      addr     <= '0;
      rsh      <= '0;
      dsh      <= '0;
      wr_addr  <= '0;
      wr_word  <= '0;
      wen      <= 1'b0;
      rd_drive <= 1'b0;
      do_q     <= 1'b0;
      wr_pend  <= 1'b0;
    end else if (!cs_q) begin
      state    <= S_IDLE;
      rd_drive <= 1'b0;
      wr_pend  <= 1'b0;
    end else if (sk_rise) begin
      unique case (state)
        S_IDLE: if (start_ok) begin
          state <= S_OPC;
          cnt   <= '0;
        end
        S_OPC: begin
          op  <= {op[0], bit_in};
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(1)) begin
            state <= S_ADDR;
            cnt   <= '0;
          end
        end
        S_ADDR: begin
          addr <= a_next;
          cnt  <= cnt + 1'b1;
          if (cnt == CNT_W'(ADDR_W - 1)) begin
            cnt <= '0;
            unique case (op)
              2'b10: begin
                state    <= S_RD;
                rd_drive <= 1'b1;
                do_q     <= 1'b0;
                rsh      <= mem[a_next];
              end
              2'b01: state <= S_WR;
              2'b00: begin
                if (a_next[ADDR_W-1 -: 2] == 2'b11) wen <= 1'b1;
                if (a_next[ADDR_W-1 -: 2] == 2'b00) wen <= 1'b0;
                state <= S_SKIP;
              end
              default: state <= S_SKIP;
            endcase
          end
        end
        S_RD: begin
          do_q <= rsh[WORD_W-1];
          if (cnt == CNT_W'(WORD_W - 1)) begin
            cnt  <= '0;
            addr <= addr + 1'b1;
            rsh  <= mem[addr + 1'b1];
          end else begin
            cnt <= cnt + 1'b1;
            rsh <= {rsh[WORD_W-2:0], 1'b0};
          end
        end
        S_WR: begin
          dsh <= {dsh[WORD_W-2:0], bit_in};
          cnt <= cnt + 1'b1;
          if (last_data) begin
            wr_word <= {dsh[WORD_W-2:0], bit_in};
            wr_addr <= addr;
            wr_pend <= wen & PROG_ON_CS_FALL;
            state   <= S_SKIP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int PROG_CYCLES = 400
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic status,
  input logic wen,
  input logic do_o,
  input logic do_oe,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_word
);
  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (!busy) busy_cnt <= 0;
    else busy_cnt <= busy_cnt + 1;
  end

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == PROG_CYCLES);

  a_r3_need_wen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wr_addr) && $stable(wr_word));

  a_r9_wen_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wen));

  a_r7_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe && busy |-> !do_o);

  a_r7_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe && status && !busy |-> do_o);
endmodule

bind mw_eeprom_slave mw_eeprom_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .status(status), .wen(wen),
  .do_o(do_o), .do_oe(do_oe), .wr_addr(wr_addr), .wr_word(wr_word)
);

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mw_eeprom_slave dut (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
                       .do_o(do_o), .do_oe(do_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sk_cycle(input logic b, output logic s, output logic oe);
    di = b;
    repeat (5) @(posedge clk);
    #1 s = do_o; oe = do_oe;
    sk = 1'b1;
    repeat (5) @(posedge clk);
    #1 sk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic s, oe;
    for (int i = n - 1; i >= 0; i--) sk_cycle(v[i], s, oe);
  endtask

  task automatic cs_on();
    cs = 1'b1;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic cs_off();
    sk = 1'b0;
    cs = 1'b0;
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic get_word(output logic [15:0] w, output bit oe_ok);
    logic s, oe;
    oe_ok = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      sk_cycle(1'b0, s, oe);
      w[i] = s;
      if (!oe) oe_ok = 1'b0;
    end
  endtask

  task automatic read_check(input logic [5:0] a, input int n, input logic [15:0] e0,
                            input logic [15:0] e1, input int lead0, input string req);
    logic s, oe;
    logic [15:0] w;
    bit ok;
    cs_on();
    send(0, lead0);
    send(3'b110, 3);
    send(a, 6);
    sk_cycle(1'b0, s, oe);
    check(s === 1'b0 && oe === 1'b1, {req, " dummy"}, {oe, s}, 2'b10);
    get_word(w, ok);
    check(ok && w === e0, {req, " word0"}, w, e0);
    if (n > 1) begin
      get_word(w, ok);
      check(ok && w === e1, {req, " word1"}, w, e1);
    end
    cs_off();
  endtask

  task automatic write_word(input logic [5:0] a, input logic [15:0] d);
    cs_on();
    send(3'b101, 3);
    send(a, 6);
    send(d, 16);
    cs_off();
  endtask

  task automatic special(input logic [1:0] top);
    cs_on();
    send(3'b100, 3);
    send({top, 4'b1010}, 6);
    cs_off();
  endtask

  task automatic t_reset();
    check(do_oe === 1'b0, "R10 oe after reset", do_oe, 0);
    read_check(6'd5, 1, 16'h0000, 16'h0, 0, "R10 array zero");
  endtask

  task automatic t_locked();
    write_word(6'd3, 16'hA5A5);
    cs_on();
    check(do_oe === 1'b0, "R3 no status when locked", do_oe, 0);
    cs_off();
    repeat (500) @(posedge clk);
    read_check(6'd3, 1, 16'h0000, 16'h0, 0, "R3 locked write ignored");
  endtask

  task automatic t_write_status();
    logic s, oe;
    special(2'b11);
    write_word(6'd3, 16'h1234);
    cs_on();
    check(do_oe === 1'b1 && do_o === 1'b0, "R7 busy status", {do_oe, do_o}, 2'b10);
    repeat (450) @(posedge clk);
    #1 check(do_oe === 1'b1 && do_o === 1'b1, "R7 ready status", {do_oe, do_o}, 2'b11);
    cs = 1'b0;
    repeat (6) @(posedge clk);
    #1 check(do_oe === 1'b0, "R8 hi-z with cs low", do_oe, 0);
    cs = 1'b1;
    repeat (6) @(posedge clk);
    #1 check(do_oe === 1'b1 && do_o === 1'b1, "R7 status persists", {do_oe, do_o}, 2'b11);
    sk_cycle(1'b1, s, oe);
    sk_cycle(1'b0, s, oe);
    check(oe === 1'b0, "R7 status cleared by start", oe, 0);
    cs_off();
    read_check(6'd3, 1, 16'h1234, 16'h0, 0, "R4 read back");
  endtask

  task automatic t_wrap();
    write_word(6'd63, 16'hBEEF);
    repeat (450) @(posedge clk);
    write_word(6'd0, 16'hCAFE);
    repeat (450) @(posedge clk);
    read_check(6'd63, 2, 16'hBEEF, 16'hCAFE, 0, "R5 wrap");
    read_check(6'd2, 2, 16'h0000, 16'h1234, 0, "R5 increment");
  endtask

  task automatic t_leading_zero();
    read_check(6'd3, 1, 16'h1234, 16'h0, 2, "R1 leading 001");
    read_check(6'd0, 1, 16'hCAFE, 16'h0, 1, "R1 leading 01");
  endtask

  task automatic t_busy_ignore();
    write_word(6'd7, 16'h7777);
    write_word(6'd8, 16'h8888);
    repeat (600) @(posedge clk);
    read_check(6'd8, 1, 16'h0000, 16'h0, 0, "R9 write during busy");
    read_check(6'd7, 1, 16'h7777, 16'h0, 0, "R6 first write kept");
  endtask

  task automatic t_abort();
    cs_on();
    send(3'b101, 3);
    send(6'd9, 6);
    send(10'h3FF, 10);
    cs_off();
    cs_on();
    check(do_oe === 1'b0, "R6 aborted write no status", do_oe, 0);
    cs_off();
    repeat (500) @(posedge clk);
    read_check(6'd9, 1, 16'h0000, 16'h0, 0, "R6 aborted write");
  endtask

  task automatic t_fill_all();
    cs_on();
    send(3'b100, 3);
    send(6'b010000, 6);
    send(16'h5555, 16);
    cs_off();
    cs_on();
    check(do_oe === 1'b0, "R2 fill-all no status", do_oe, 0);
    cs_off();
    repeat (500) @(posedge clk);
    read_check(6'd10, 1, 16'h0000, 16'h0, 0, "R2 fill-all ignored");
  endtask

  task automatic t_disable();
    special(2'b00);
    write_word(6'd11, 16'h1111);
    repeat (500) @(posedge clk);
    read_check(6'd11, 1, 16'h0000, 16'h0, 0, "R3 disabled write ignored");
    read_check(6'd3, 1, 16'h1234, 16'h0, 0, "R4 read while locked");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_locked();
    t_write_status();
    t_wrap();
    t_leading_zero();
    t_busy_ignore();
    t_abort();
    t_fill_all();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule